// File: doc/BRIEF.md
# I2C Master Clock and Bus Condition Timer

This block produces the SCL waveform and the start, repeated-start and stop conditions for an I2C master, all timed from the block's clock. Software-level logic above it (byte shifting, acknowledge handling) issues one command pulse at a time: a start, a repeated start, one data bit, or a stop. The block then drives the open-drain pull-down enables for SCL and SDA and raises a one-cycle ready pulse when the command has finished.

Two 8-bit counts set the timing. The low-phase count is the separate low setting when that is non-zero, and the main baud setting when it is zero. Every timed low interval lasts the low-phase count plus 5 cycles. This covers the SCL low phase, the start and repeated-start hold, the repeated-start setup, the stop setup, and the bus-free gap after a stop. The SCL high phase always lasts baud plus 5 cycles. That count starts only once the sampled SCL line, passed through a two-flop synchronizer, reads high. Slow rise time and slaves that hold SCL low therefore lengthen the period.

Top module: `i2c_scl_timer`

## Requirements
- R1: After a synchronous reset, scl_pd, sda_pd and ready are all low and the bus is idle.
- R2: The low interval is Lc = baud_low+5 cycles when baud_low is non-zero, and Lc = baud+5 cycles when baud_low is zero.
- R3: A start, accepted only while idle, sets sda_pd while scl_pd stays low. It then sets scl_pd Lc cycles after the accepting edge, and ready is asserted with both pull-downs set.
- R4: A data bit, accepted only while the bus is held, drives sda_pd to the inverse of bit_val and keeps scl_pd set for Lc cycles. It then clears scl_pd. The high count begins on the edge after the second synchronizer flop reads high, which is W = R+4 cycles after release when the line rises R cycles after the block first sees the release. ready comes Lc+W+Hc cycles after acceptance with scl_pd set and sda_pd unchanged.
- R5: The high phase Hc is always baud+5 cycles, whatever the value of baud_low.
- R6: A repeated start first clears sda_pd during an Lc low phase. It then releases SCL and waits for the line to read high. It keeps SDA released for an Lc setup time and then sets sda_pd for an Lc hold time. Finally it sets scl_pd. ready comes 3*Lc+W cycles after acceptance, with both pull-downs set.
- R7: A stop first sets sda_pd during an Lc low phase. It then releases SCL, waits for the line to read high, and waits an Lc setup time. Next it clears sda_pd and waits an Lc bus-free gap. ready comes 3*Lc+W cycles after acceptance, with both pull-downs clear and the bus idle.
- R8: ready is high for exactly one cycle per completed command, and never at any other time.
- R9: Commands that arrive while a command is in progress are ignored. Commands that do not fit the bus state are also ignored: anything but start while idle, or start while held.
- R10: When several valid commands arrive in the same cycle while the bus is held, repeated start wins over stop, and stop wins over data bit.
- R11: Each extra cycle of SCL rise delay adds one cycle to the released SCL period and to the command latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous reset, active high |
| baud | input | BAUD_W | Main count; always times the high phase |
| baud_low | input | BAUD_W | Low-phase count; zero means use baud |
| cmd_start | input | 1 | Start condition request pulse |
| cmd_rstart | input | 1 | Repeated start request pulse |
| cmd_bit | input | 1 | Data bit request pulse |
| cmd_stop | input | 1 | Stop condition request pulse |
| bit_val | input | 1 | Data value for a bit command |
| scl_in | input | 1 | Sampled SCL bus level |
| scl_pd | output | 1 | SCL pull-down enable |
| sda_pd | output | 1 | SDA pull-down enable |
| ready | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with the default 8-bit count width and sweeps the settings across four cases. Baud 3 with a zero low count exercises the shared-count fall-back. Baud 2 with low count 7 separates the low and high timing. Both counts at 0 give the shortest phases of 5 cycles. Both counts at 255 give the widest phases, 260 cycles, and check that the padded count does not overflow. The bench varies the rise delay between 0 and 10 cycles to show that a slow line lengthens the released period cycle for cycle. With the long 260-cycle start hold, there is room to send stray commands in mid-sequence and confirm that they are dropped.

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BAUD_W-1:0] baud,
  input  logic [BAUD_W-1:0] baud_low,
  input  logic              cmd_start,
  input  logic              cmd_rstart,
  input  logic              cmd_bit,
  input  logic              cmd_stop,
  input  logic              bit_val,
  input  logic              scl_in,
  output logic              scl_pd,
  output logic              sda_pd,
  output logic              ready
);
  localparam int CW  = BAUD_W + 1;
  localparam int PAD = 5;

  typedef enum logic [3:0] {
    IDLE, HELD, S_HOLD,
    B_LOW, B_WAIT, B_HIGH,
    R_LOW, R_WAIT, R_SETUP, R_HOLD,
    P_LOW, P_WAIT, P_SETUP, P_BUF
  } st_t;

  st_t st, nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic s1, s2, sda_q, rst_d;

  wire [CW-1:0] low_load  = ((baud_low != '0) ? CW'(baud_low) : CW'(baud)) + CW'(PAD - 1);
  wire [CW-1:0] high_load = CW'(baud) + CW'(PAD - 1);

  wire waiting = st inside {B_WAIT, R_WAIT, P_WAIT};
  wire timed   = st inside {S_HOLD, B_LOW, B_HIGH, R_LOW, R_SETUP, R_HOLD, P_LOW, P_SETUP, P_BUF};
  wire busy    = timed | waiting;
  wire step    = timed ? (cnt == '0) : (waiting & s2);

  assign scl_pd = st inside {HELD, B_LOW, R_LOW, P_LOW};
  assign sda_pd = sda_q;

  always_comb begin
    nx     = st;
    cnt_nx = timed ? cnt - 1'b1 : cnt;
    case (st)
      IDLE:    if (cmd_start) begin nx = S_HOLD; cnt_nx = low_load; end
      HELD:    if (cmd_rstart)   begin nx = R_LOW; cnt_nx = low_load; end
               else if (cmd_stop) begin nx = P_LOW; cnt_nx = low_load; end
               else if (cmd_bit)  begin nx = B_LOW; cnt_nx = low_load; end
      S_HOLD:  if (step) nx = HELD;
      B_LOW:   if (step) nx = B_WAIT;
      B_WAIT:  if (step) begin nx = B_HIGH; cnt_nx = high_load; end
      B_HIGH:  if (step) nx = HELD;
      R_LOW:   if (step) nx = R_WAIT;
      R_WAIT:  if (step) begin nx = R_SETUP; cnt_nx = low_load; end
      R_SETUP: if (step) begin nx = R_HOLD;  cnt_nx = low_load; end
      R_HOLD:  if (step) nx = HELD;
      P_LOW:   if (step) nx = P_WAIT;
      P_WAIT:  if (step) begin nx = P_SETUP; cnt_nx = low_load; end
      P_SETUP: if (step) begin nx = P_BUF;   cnt_nx = low_load; end
      P_BUF:   if (step) nx = IDLE;
      default: nx = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= IDLE;
      cnt   <= '0;
      sda_q <= 1'b0;
      ready <= 1'b0;
      s1    <= 1'b0;
      s2    <= 1'b0;
    end else begin
      st    <= nx;
      cnt   <= cnt_nx;
      s1    <= scl_in;
      s2    <= s1;
      ready <= busy & step & (nx inside {HELD, IDLE});
      if (st == IDLE && nx == S_HOLD)        sda_q <= 1'b1;
      else if (st == HELD && nx == B_LOW)    sda_q <= ~bit_val;
      else if (st == HELD && nx == R_LOW)    sda_q <= 1'b0;
      else if (st == HELD && nx == P_LOW)    sda_q <= 1'b1;
      else if (st == R_SETUP && nx == R_HOLD) sda_q <= 1'b1;
      else if (st == P_SETUP && nx == P_BUF)  sda_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk)
    if (rst_d && !rst)
      a_r1_reset_state: assert (!scl_pd && !sda_pd && !ready && st == IDLE);

  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !step) |=> $stable(st));

  a_r4_high_after_sync: assert property (@(posedge clk) disable iff (rst)
    (st == B_HIGH && $past(st) != B_HIGH) |-> $past(s2));

  a_r5_high_end: assert property (@(posedge clk) disable iff (rst)
    (st == B_HIGH && cnt == '0) |=> (ready && scl_pd));

  a_r7_stop_end: assert property (@(posedge clk) disable iff (rst)
    (st == P_BUF && cnt == '0) |=> (ready && !scl_pd && !sda_pd));
endmodule

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] baud = 8'd3, baud_low = 8'd0;
  logic c_start = 0, c_rstart = 0, c_bit = 0, c_stop = 0, bval = 0;
  logic line = 1'b1;
  logic scl_pd, sda_pd, ready;
  int rise = 0, rc = 0, cyc = 0;
  int n_chk = 0, n_fail = 0;

  typedef struct {int lat; logic scl; logic sda; string tag; int t0;} exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  i2c_scl_timer #(.BAUD_W(8)) u_dut (
    .clk(clk), .rst(rst), .baud(baud), .baud_low(baud_low),
    .cmd_start(c_start), .cmd_rstart(c_rstart), .cmd_bit(c_bit), .cmd_stop(c_stop),
    .bit_val(bval), .scl_in(line), .scl_pd(scl_pd), .sda_pd(sda_pd), .ready(ready));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (scl_pd) begin line <= 1'b0; rc <= 0; end
    else if (rc >= rise) line <= 1'b1;
    else rc <= rc + 1;
  end

  function automatic void chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endfunction

  always @(negedge clk) begin
    if (ready) begin
      if (q.size() == 0) chk(0, "R8 unexpected ready", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc - e.t0 == e.lat, {e.tag, " latency"}, cyc - e.t0, e.lat);
        chk(scl_pd === e.scl && sda_pd === e.sda, {e.tag, " lines"},
            int'({scl_pd, sda_pd}), int'({e.scl, e.sda}));
      end
    end
  end

  always @(posedge clk)
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end

  task automatic pulse(input logic [3:0] m, input logic b);
    @(negedge clk);
    {c_start, c_rstart, c_stop, c_bit} = m;
    bval = b;
    @(negedge clk);
    {c_start, c_rstart, c_stop, c_bit} = 4'b0;
  endtask

  task automatic issue(input logic [3:0] m, input logic b, input int lat,
                       input logic mscl, input logic msda, input logic escl, input logic esda,
                       input string tag, input bit wait_done);
    exp_t e;
    @(negedge clk);
    {c_start, c_rstart, c_stop, c_bit} = m;
    bval = b;
    e.lat = lat; e.scl = escl; e.sda = esda; e.tag = tag; e.t0 = cyc + 1;
    q.push_back(e);
    @(negedge clk);
    {c_start, c_rstart, c_stop, c_bit} = 4'b0;
    chk(scl_pd === mscl && sda_pd === msda, {tag, " first phase"},
        int'({scl_pd, sda_pd}), int'({mscl, msda}));
    if (wait_done) while (q.size() != 0) @(negedge clk);
  endtask

  localparam logic [3:0] ST = 4'b1000, RS = 4'b0100, SP = 4'b0010, BT = 4'b0001;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scl_pd === 1'b0, "R1 scl_pd after reset", scl_pd, 0);
    chk(sda_pd === 1'b0, "R1 sda_pd after reset", sda_pd, 0);
    chk(ready === 1'b0, "R1 ready after reset", ready, 0);

    // R9: commands that do not fit an idle bus
    pulse(BT, 1'b0); pulse(SP, 1'b0); pulse(RS, 1'b0);
    repeat (40) @(negedge clk);
    chk(scl_pd === 1'b0 && sda_pd === 1'b0, "R9 idle ignores non-start",
        int'({scl_pd, sda_pd}), 0);

    // baud 3, low 0: Lc 8, Hc 8 (R2 fall-back)
    baud = 8'd3; baud_low = 8'd0; rise = 0;
    issue(ST, 0, 8,  0, 1, 1, 1, "R2 R3 start", 1);
    issue(BT, 1, 20, 1, 0, 1, 0, "R4 bit one", 1);
    issue(BT, 0, 20, 1, 1, 1, 1, "R4 bit zero", 1);
    issue(RS, 0, 28, 1, 0, 1, 1, "R6 repeated start", 1);
    rise = 3;
    issue(BT, 0, 23, 1, 1, 1, 1, "R11 bit with rise 3", 1);
    rise = 0;
    issue(SP, 0, 28, 1, 1, 0, 0, "R7 stop", 1);

    // baud 2, low 7: Lc 12, Hc 7
    baud = 8'd2; baud_low = 8'd7;
    issue(ST, 0, 12, 0, 1, 1, 1, "R2 start with low count", 1);
    issue(BT, 1, 23, 1, 0, 1, 0, "R5 high from baud", 1);
    issue(SP | BT, 0, 40, 1, 1, 0, 0, "R10 stop over bit", 1);

    // both 0: Lc 5, Hc 5
    baud = 8'd0; baud_low = 8'd0;
    issue(ST, 0, 5, 0, 1, 1, 1, "R2 minimum start", 1);
    rise = 10;
    issue(BT, 1, 24, 1, 0, 1, 0, "R11 bit with rise 10", 1);
    rise = 0;
    issue(RS | SP | BT, 0, 19, 1, 0, 1, 1, "R10 rstart over stop and bit", 1);
    issue(SP, 0, 19, 1, 1, 0, 0, "R7 minimum stop", 1);

    // both 255: Lc 260, Hc 260
    baud = 8'd255; baud_low = 8'd255;
    issue(ST, 0, 260, 0, 1, 1, 1, "R9 start not disturbed", 0);
    repeat (3) @(negedge clk);
    pulse(SP | BT, 1'b1);
    pulse(RS, 1'b0);
    while (q.size() != 0) @(negedge clk);
    issue(BT, 0, 524, 1, 1, 1, 1, "R5 widest bit", 1);
    issue(SP, 0, 784, 1, 1, 0, 0, "R7 widest stop", 1);

    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R8 every command completed once", q.size(), 0);
    chk(scl_pd === 1'b0 && sda_pd === 1'b0, "R7 bus idle at end",
        int'({scl_pd, sda_pd}), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule